// File: doc/BRIEF.md
# Flash page-mode read front end

This block is a clock-driven behavioural model of the read side of a parallel NOR flash device. It offers an asynchronous page read. A host drives chip enable, output enable, write enable, an address and a byte/word width select. The block answers on a 16-bit data bus, with a flag that marks the data as valid. A sense step fills an eight-word page buffer from the cell array. A read that misses the buffer waits the long initial delay. A read that hits a buffered word waits only the short page delay.

A small command path accepts writes. Each write cycle captures its code on the falling edge of write enable while chip enable is low. The commands return to array reads, enter register reads (Clear Status) or set a volatile configuration register in two write cycles. In register-read mode a sense loads only the one addressed word. Any other offset of that page has to be sensed again.

Top module: `nor_page_reader`

## Requirements
- R1: While `rst_n` is low the data bus is released: `dq_oe`=0, `dq_valid`=0 and `dq_out`=0.
- R2: The bus is driven (`dq_oe`=1) only when `ce_n`=0, `oe_n`=0 and `we_n`=1. Otherwise `dq_oe`=0, `dq_valid`=0 and `dq_out`=0.
- R3: A read that misses the page raises `dq_valid` exactly INIT_DLY (8) rising edges after the address is presented. The data comes from the starting address. In array mode, word index w = addr[ADDR_W-1:1] taken as 16 bits holds {w[7:0]^w[15:8]^8'h5A, w[7:0]+8'h31}.
- R4: Once a page is loaded, a read of any word in the same page (same addr[ADDR_W-1:4]) is valid PAGE_DLY (2) edges after the address changes. This holds in any order and any number of times, and the data stays stable while the address is held.
- R5: A change in any address bit from bit 4 upward starts a new sense, so the next read takes INIT_DLY, including a return to an earlier page.
- R6: A clock edge that samples `ce_n`=1 discards the page, so the next read takes INIT_DLY.
- R7: With `byte_mode`=1, addr[3:0] selects a byte. addr[0]=0 gives the low byte of the word and addr[0]=1 the high byte, on `dq_out[7:0]` with `dq_out[15:8]`=0. With `byte_mode`=0, addr[0] is ignored: changing only it keeps the data valid with no delay.
- R8: A miss presented while a sense is in progress restarts the sense. Data is valid INIT_DLY edges after the latest address.
- R9: Write code 0x50 enters register-read mode and 0xFF returns to array mode. Both are taken from `wr_data` on a falling edge of `we_n` with `ce_n`=0. Any unrecognised code leaves the mode unchanged.
- R10: In register-read mode a sense fills only the addressed word. Offset addr[3:1]=0 reads status 16'h0080, offset 1 reads the configuration register, and other offsets read 0. A read of another offset in the same page takes INIT_DLY.
- R11: Code 0x60 followed by code 0x04 loads the configuration register from addr[15:0] of the second write and selects array mode. If the second code is not 0x04, the setup is dropped and that code is decoded as a new command.
- R12: Reset clears the configuration register to 0 and selects array mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset (device reset pin) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_mode | input | 1 | 1 selects the 8-bit bus width, 0 the 16-bit width |
| addr | input | ADDR_W | Byte address; also carries the configuration value on writes |
| wr_data | input | 8 | Command code captured on a write cycle |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| dq_valid | output | 1 | Read data is valid for the present address |

## Verification
On every cycle, the assertions check the bus release conditions and the zero upper byte in byte mode. They also check that data never shows valid in the cycle the word address moves, that it stays invalid for a cycle after the upper address bits change, and that it holds steady while the address is held. The exact latencies of hits, misses and restarted senses can only be shown by the bench's scenarios. The same goes for reloads on a chip-enable toggle, the word and byte selection against a reference array, the single-word register loads, and the two-cycle configuration sequence with its dropped variants.

// File: rtl/nor_rd_pkg.sv
// Package: shared types and the computed array content for the page reader.
// Assumes: a page of eight 16-bit words, addressed by byte addresses.
package nor_rd_pkg;

    localparam int PAGE_WORDS = 8;
    localparam int SLOT_W     = 3;
    localparam logic [15:0] STATUS_READY = 16'h0080;

    typedef enum logic [0:0] {
        MODE_ARRAY = 1'b0,
        MODE_REG   = 1'b1
    } rd_mode_e;

    // Content of cell word w (the array is a fixed pattern, not stored).
    function automatic logic [15:0] cell_word(input logic [15:0] w);
        return {w[7:0] ^ w[15:8] ^ 8'h5A, w[7:0] + 8'h31};
    endfunction

endpackage

// File: rtl/nor_cell_array.sv
// Module: cell array and register space seen by the sense step.
// Produces the eight words of the page named by tag_i, plus a mask of the
// slots a sense may fill. In register mode only the addressed slot is filled.
// Assumes: purely combinational; the caller registers the result.
module nor_cell_array
    import nor_rd_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic [TAG_W-1:0]             tag_i,
    input  logic [SLOT_W-1:0]            slot_i,
    input  rd_mode_e                     mode_i,
    input  logic [15:0]                  cfg_i,
    output logic [PAGE_WORDS-1:0][15:0]  words_o,
    output logic [PAGE_WORDS-1:0]        mask_o
);

    localparam int WI_W = TAG_W + SLOT_W;

    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_slot
        logic [WI_W-1:0] widx;
        logic [15:0]     reg_word;

        // Word index of this slot within the cell array.
        assign widx = {tag_i, SLOT_W'(g)};

        // Register space: status at offset 0, configuration at offset 1.
        always_comb begin
            if (g == 0)      reg_word = STATUS_READY;
            else if (g == 1) reg_word = cfg_i;
            else             reg_word = 16'h0000;
        end

        // Pick the array or register word and whether the slot is filled.
        always_comb begin
            if (mode_i == MODE_REG) begin
                words_o[g] = reg_word;
                mask_o[g]  = (slot_i == SLOT_W'(g));
            end else begin
                words_o[g] = cell_word(16'(widx));
                mask_o[g]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
// Module: command path of the page reader.
// Takes a command code on each falling edge of we_n while ce_n is low, keeps
// the read mode and the volatile configuration register, and handles the
// two-cycle configuration sequence.
// Assumes: we_n is sampled by clk; one code per low pulse of we_n.
module nor_cmd_decoder
    import nor_rd_pkg::*;
#(
    parameter logic [7:0] CMD_READ_ARRAY  = 8'hFF,
    parameter logic [7:0] CMD_CFG_SETUP   = 8'h60,
    parameter logic [7:0] CMD_CFG_CONFIRM = 8'h04,
    parameter logic [7:0] CMD_CLR_STATUS  = 8'h50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic [7:0]  code_i,
    input  logic [15:0] cfg_data_i,
    output rd_mode_e    mode_o,
    output logic [15:0] cfg_o,
    output logic        wr_stb_o
);

    logic we_q;
    logic cfg_pend_q;

    // A write cycle begins when we_n falls with the chip selected.
    assign wr_stb_o = !ce_n && !we_n && we_q;

    // Track we_n, decode codes, and update the mode and configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q       <= 1'b1;
            cfg_pend_q <= 1'b0;
            mode_o     <= MODE_ARRAY;
            cfg_o      <= 16'h0000;
        end else begin
            we_q <= we_n;
            if (wr_stb_o) begin
                if (cfg_pend_q && code_i == CMD_CFG_CONFIRM) begin
                    cfg_o      <= cfg_data_i;
                    mode_o     <= MODE_ARRAY;
                    cfg_pend_q <= 1'b0;
                end else begin
                    cfg_pend_q <= (code_i == CMD_CFG_SETUP);
                    if (code_i == CMD_READ_ARRAY)      mode_o <= MODE_ARRAY;
                    else if (code_i == CMD_CLR_STATUS) mode_o <= MODE_REG;
                end
            end
        end
    end

endmodule

// File: rtl/nor_page_ctrl.sv
// Module: page buffer with hit/miss detection and access timing.
// A new access starts when the read becomes active or the access key changes.
// A hit counts PAGE_DLY edges. A miss senses a page for INIT_DLY edges, and a
// new miss during a sense restarts it.
// Assumes: INIT_DLY >= 2 and PAGE_DLY >= 1; key_i has bit 0 cleared by the
// caller in word mode.
module nor_page_ctrl
    import nor_rd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int INIT_DLY = 8,
    parameter int PAGE_DLY = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         read_en_i,
    input  logic                         flush_i,
    input  logic [ADDR_W-1:0]            key_i,
    input  logic [PAGE_WORDS-1:0][15:0]  words_i,
    input  logic [PAGE_WORDS-1:0]        mask_i,
    output logic [ADDR_W-5:0]            sense_tag_o,
    output logic [SLOT_W-1:0]            sense_slot_o,
    output logic [15:0]                  word_o,
    output logic                         valid_o
);

    localparam int TAG_W = ADDR_W - 4;
    localparam int MAX_D = (INIT_DLY > PAGE_DLY) ? INIT_DLY : PAGE_DLY;
    localparam int CNT_W = $clog2(MAX_D + 1);

    logic [PAGE_WORDS-1:0][15:0] buf_q;
    logic [PAGE_WORDS-1:0]       vld_q;
    logic [ADDR_W-1:0]           acc_q;
    logic                        active_q;
    logic                        sensing_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [TAG_W-1:0]            key_tag;
    logic [SLOT_W-1:0]           key_slot;
    logic                        new_acc;
    logic                        hit;

    assign key_tag  = key_i[ADDR_W-1:4];
    assign key_slot = key_i[3:1];

    // Classify the present address against the buffered page.
    always_comb begin
        new_acc = read_en_i && (!active_q || key_i != acc_q);
        hit     = !sensing_q && (sense_tag_o == key_tag) && vld_q[key_slot];
    end

    // Run the access timer, the sense and the page buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q        <= '0;
            vld_q        <= '0;
            acc_q        <= '0;
            active_q     <= 1'b0;
            sensing_q    <= 1'b0;
            cnt_q        <= '0;
            sense_tag_o  <= '0;
            sense_slot_o <= '0;
        end else if (!read_en_i) begin
            active_q  <= 1'b0;
            sensing_q <= 1'b0;
            cnt_q     <= '0;
            if (flush_i) vld_q <= '0;
        end else if (new_acc) begin
            acc_q    <= key_i;
            active_q <= 1'b1;
            if (hit) begin
                cnt_q <= CNT_W'(PAGE_DLY - 1);
            end else begin
                sensing_q    <= 1'b1;
                vld_q        <= '0;
                sense_tag_o  <= key_tag;
                sense_slot_o <= key_slot;
                cnt_q        <= CNT_W'(INIT_DLY - 1);
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (sensing_q && cnt_q == CNT_W'(1)) begin
                sensing_q <= 1'b0;
                vld_q     <= mask_i;
                for (int i = 0; i < PAGE_WORDS; i++) begin
                    if (mask_i[i]) buf_q[i] <= words_i[i];
                end
            end
        end
    end

    // Data is valid once the timer of the present access has run out.
    assign valid_o = read_en_i && active_q && (acc_q == key_i) &&
                     (cnt_q == '0) && !sensing_q;
    assign word_o  = buf_q[key_slot];

endmodule

// File: rtl/nor_page_reader.sv
// Module: top of the flash page-mode read front end.
// Combines the command decoder, the page controller and the cell array, and
// forms the bus outputs with word or byte selection.
// Assumes: ADDR_W >= 16 so the configuration value fits on the address bus.
module nor_page_reader
    import nor_rd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int INIT_DLY = 8,
    parameter int PAGE_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic              dq_valid
);

    localparam int TAG_W = ADDR_W - 4;

    rd_mode_e                    mode;
    logic [15:0]                 cfg;
    logic                        wr_stb;
    logic                        read_en;
    logic [ADDR_W-1:0]           key;
    logic [TAG_W-1:0]            sense_tag;
    logic [SLOT_W-1:0]           sense_slot;
    logic [PAGE_WORDS-1:0][15:0] words;
    logic [PAGE_WORDS-1:0]       mask;
    logic [15:0]                 page_word;
    logic                        page_valid;

    // A read needs the chip and outputs enabled with no write or reset.
    assign read_en = rst_n && !ce_n && !oe_n && we_n;

    // In word mode address bit 0 takes no part in the access.
    assign key = byte_mode ? addr : {addr[ADDR_W-1:1], 1'b0};

    nor_cmd_decoder i_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .code_i     (wr_data),
        .cfg_data_i (addr[15:0]),
        .mode_o     (mode),
        .cfg_o      (cfg),
        .wr_stb_o   (wr_stb)
    );

    nor_page_ctrl #(
        .ADDR_W   (ADDR_W),
        .INIT_DLY (INIT_DLY),
        .PAGE_DLY (PAGE_DLY)
    ) i_page (
        .clk          (clk),
        .rst_n        (rst_n),
        .read_en_i    (read_en),
        .flush_i      (ce_n || wr_stb),
        .key_i        (key),
        .words_i      (words),
        .mask_i       (mask),
        .sense_tag_o  (sense_tag),
        .sense_slot_o (sense_slot),
        .word_o       (page_word),
        .valid_o      (page_valid)
    );

    nor_cell_array #(
        .TAG_W (TAG_W)
    ) i_cells (
        .tag_i   (sense_tag),
        .slot_i  (sense_slot),
        .mode_i  (mode),
        .cfg_i   (cfg),
        .words_o (words),
        .mask_o  (mask)
    );

    // Form the bus: word, or one byte on the low lane, only when valid.
    always_comb begin
        dq_oe    = read_en;
        dq_valid = page_valid;
        if (!page_valid)   dq_out = 16'h0000;
        else if (byte_mode) dq_out = {8'h00, addr[0] ? page_word[15:8] : page_word[7:0]};
        else               dq_out = page_word;
    end

endmodule

// File: rtl/nor_page_reader_chk.sv
// Module: assertion checker bound to the page reader top.
// Observes the top ports only.
// Assumes: INIT_DLY >= 2, so data is still invalid one edge after a reload.
module nor_page_reader_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              byte_mode,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       dq_out,
    input logic              dq_oe,
    input logic              dq_valid
);

    // Reset keeps the bus released.
    always_comb begin
        if (!rst_n) begin
            p_reset_release_r1: assert (!dq_oe && !dq_valid && dq_out == 16'h0000);
        end
    end

    // Without a full read condition the bus is released.
    p_bus_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |-> (!dq_oe && !dq_valid && dq_out == 16'h0000));

    // With a full read condition the bus is driven.
    p_bus_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |-> dq_oe);

    // Data is never valid in the cycle the word address moves.
    p_no_early_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr[ADDR_W-1:1]) |-> !dq_valid);

    // Valid data holds while the address and width are held.
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && $past(dq_valid) && $stable(addr) && $stable(byte_mode))
        |-> $stable(dq_out));

    // A page change keeps data invalid into the next cycle.
    p_upper_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr[ADDR_W-1:4]) |=> !dq_valid);

    // Byte mode drives only the low lane.
    p_byte_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && dq_valid) |-> (dq_out[15:8] == 8'h00));

endmodule

bind nor_page_reader nor_page_reader_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .byte_mode (byte_mode),
    .addr      (addr),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .dq_valid  (dq_valid)
);

// File: tb/test_nor_page_reader.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the page reader, one task per scenario.
module test_nor_page_reader;

    localparam int ADDR_W = 16;
    localparam int T_INIT = 8;
    localparam int T_PAGE = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_n = 1'b1;
    logic              we_n = 1'b1;
    logic              byte_mode = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wr_data = 8'h00;
    logic [15:0]       dq_out;
    logic              dq_oe;
    logic              dq_valid;

    int checks = 0;
    int fails  = 0;

    nor_page_reader #(.ADDR_W(ADDR_W), .INIT_DLY(T_INIT), .PAGE_DLY(T_PAGE)) i_nor_page_reader (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .byte_mode(byte_mode), .addr(addr), .wr_data(wr_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid)
    );

    always #2.5 clk = ~clk;

    // Reference array word for a byte address.
    function automatic logic [15:0] ref_word(input logic [15:0] a);
        logic [15:0] w;
        w = a >> 1;
        return {w[7:0] ^ w[15:8] ^ 8'h5A, w[7:0] + 8'h31};
    endfunction

    function automatic logic [15:0] ref_byte(input logic [15:0] a);
        logic [15:0] w;
        w = ref_word(a);
        return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present a read address and measure edges until data is valid.
    task automatic do_read(input logic [15:0] a, input int exp_lat, input logic [15:0] exp_data, input string req);
        int lat;
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        lat = 0;
        while (!dq_valid && lat < 40) begin
            @(posedge clk); @(negedge clk); #1;
            lat++;
        end
        check(req, "latency", lat, exp_lat);
        check(req, "data", dq_out, exp_data);
    endtask

    task automatic do_write(input logic [7:0] code, input logic [15:0] a);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; wr_data = code;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle_oe();
        @(negedge clk);
        oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        check("R1", "dq_oe in reset", dq_oe, 1'b0);
        check("R1", "dq_valid in reset", dq_valid, 1'b0);
        check("R1", "dq_out in reset", dq_out, 16'h0000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_miss_hit();
        do_read(16'h0024, T_INIT, ref_word(16'h0024), "R3");
        do_read(16'h0020, T_PAGE, ref_word(16'h0020), "R4");
        do_read(16'h002E, T_PAGE, ref_word(16'h002E), "R4");
        do_read(16'h0024, T_PAGE, ref_word(16'h0024), "R4");
        // Word mode ignores address bit 0: data stays valid at once.
        do_read(16'h0025, 0, ref_word(16'h0024), "R7");
        idle_oe();
        do_read(16'h002A, T_PAGE, ref_word(16'h002A), "R4");
    endtask

    task automatic t_upper();
        do_read(16'h0444, T_INIT, ref_word(16'h0444), "R5");
        do_read(16'h0024, T_INIT, ref_word(16'h0024), "R5");
    endtask

    task automatic t_ce_toggle();
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        do_read(16'h0026, T_INIT, ref_word(16'h0026), "R6");
    endtask

    task automatic t_byte();
        idle_oe();
        byte_mode = 1'b1;
        do_read(16'h0031, T_INIT, ref_byte(16'h0031), "R7");
        do_read(16'h0030, T_PAGE, ref_byte(16'h0030), "R7");
        do_read(16'h003F, T_PAGE, ref_byte(16'h003F), "R7");
        idle_oe();
        byte_mode = 1'b0;
    endtask

    task automatic t_restart();
        @(negedge clk);
        addr = 16'h0050; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (3) @(negedge clk);
        do_read(16'h0160, T_INIT, ref_word(16'h0160), "R8");
    endtask

    task automatic t_release();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        #1;
        check("R2", "dq_oe with oe_n high", dq_oe, 1'b0);
        check("R2", "dq_out with oe_n high", dq_out, 16'h0000);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0;
        #1;
        check("R2", "dq_oe with ce_n high", dq_oe, 1'b0);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; wr_data = 8'h00; we_n = 1'b0;
        #1;
        check("R2", "dq_oe with we_n low", dq_oe, 1'b0);
        check("R2", "dq_valid with we_n low", dq_valid, 1'b0);
        @(negedge clk);
        we_n = 1'b1;
        #1;
        check("R2", "dq_oe with full read", dq_oe, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_regmode();
        do_write(8'h50, 16'h0000);
        do_read(16'h0040, T_INIT, 16'h0080, "R10");
        do_read(16'h0042, T_INIT, 16'h0000, "R10");
        do_read(16'h0040, T_INIT, 16'h0080, "R10");
        do_read(16'h0046, T_INIT, 16'h0000, "R10");
        do_write(8'h33, 16'h0000);
        do_read(16'h0040, T_INIT, 16'h0080, "R9");
        do_write(8'hFF, 16'h0000);
        do_read(16'h0040, T_INIT, ref_word(16'h0040), "R9");
    endtask

    task automatic t_config();
        do_write(8'h60, 16'h1234);
        do_write(8'h04, 16'hBEEF);
        do_read(16'h0080, T_INIT, ref_word(16'h0080), "R11");
        do_write(8'h50, 16'h0000);
        do_read(16'h0082, T_INIT, 16'hBEEF, "R11");
        do_write(8'h60, 16'h1111);
        do_write(8'hFF, 16'h2222);
        do_read(16'h0080, T_INIT, ref_word(16'h0080), "R11");
        do_write(8'h60, 16'h3333);
        do_write(8'h50, 16'h4444);
        do_read(16'h0082, T_INIT, 16'hBEEF, "R11");
        do_read(16'h0080, T_INIT, 16'h0080, "R11");
    endtask

    task automatic t_reset_clears();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read(16'h0040, T_INIT, ref_word(16'h0040), "R12");
        do_write(8'h50, 16'h0000);
        do_read(16'h0082, T_INIT, 16'h0000, "R12");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_miss_hit();
        t_upper();
        t_ce_toggle();
        t_byte();
        t_restart();
        t_release();
        t_regmode();
        t_config();
        t_reset_clears();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule